// File: doc/BRIEF.md
# GPIO Bank with Edge and Level Interrupts

This block is a bank of 32 general-purpose pins behind a 32-bit word register port. Each pin can be an input or an output. Software changes direction and output drive through separate set and clear registers, so that one write can change chosen pins without disturbing the others. The current pin level can be read back through a two-flop synchroniser.

The eight lowest pins can also raise interrupts. A shared interrupt-control word has four 8-bit lanes:
- rising enable in bits 7:0
- falling enable in bits 15:8
- debounce enable in bits 23:16
- level-mode enable in bits 31:24

In edge mode the rise and fall bits select which transitions latch a sticky status bit. In level mode the same two bits select whether a high or a low pin is the active level. Status bits are acknowledged by writing ones to a clear register. A single registered interrupt line, the OR of all status bits, goes to the parent controller.

Top module: `gpio_irq_bank`

## Requirements
- R1: After synchronous reset, direction, output latch, control word, status, read data and `irq` are all zero. Every pin is then an input with interrupts off.
- R2: A write to offset 0x04 sets the direction bits written as 1, and a write to 0x08 clears them. Direction 1 means output. Bits written as 0 are unchanged. The direction word drives `pin_oe` and reads back at 0x00.
- R3: A write to 0x10 sets output-latch bits and a write to 0x14 clears them; 0 bits are unchanged. The latch drives `pin_out` and reads back at 0x10.
- R4: A read returns its data on `bus_rdata` one clock after the request. Offset 0x0C returns the pin inputs after a two-flop synchroniser.
- R5: A write to 0x18 sets control-word bits and a write to 0x1C clears them; the word reads back at 0x18. Bit n of each lane refers to pin n.
- R6: In edge mode with the rise bit set, a 0-to-1 input change latches status bit n on the third clock edge after the change. A 1-to-0 change does not latch it.
- R7: In edge mode the fall bit catches 1-to-0 changes, and with both bits set either change latches.
- R8: In level mode the rise bit makes a high pin active and the fall bit makes a low pin active. While the active level persists, the status bit stays set even across clear writes.
- R9: Writing 1 to bit n at offset 0x20 clears status bit n. If a new event for that pin arrives in the same cycle, the status bit stays set. Status reads at 0x24.
- R10: Pins 8 to 31 never raise interrupts, and status bits 31:8 always read as zero.
- R11: With debounce enabled, a change reaches detection only after the synchronised input has held the new value for DEB_CYC (default 16) consecutive cycles. With the default, a rising edge latches on the 19th clock edge after the change, and shorter pulses are dropped.
- R12: `irq` is high exactly when any status bit is set, and updates on the same clock edge as the status.
- R13: Clearing a pin's rise and fall enables through 0x1C stops new events for that pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pin input levels |
| pin_out | output | 32 | Output latch |
| pin_oe | output | 32 | Output enable, from the direction word |
| irq | output | 1 | Combined interrupt to the parent |

## Verification
Register writes take effect on the edge that samples them. Read data appears on the edge after the request, and the bench samples it at the following falling edge. An input change needs two synchroniser edges and then the status/`irq` edge, so status is due on the third edge, or on the 19th with debounce. The bench samples one edge before and on the due edge to pin this down. The clear/event race is produced by placing the clear write on exactly the edge where the new edge event lands.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 6;
  localparam int LANE_W = 8;

  // lane index inside the interrupt-control word
  localparam int LN_RISE = 0;
  localparam int LN_FALL = 1;
  localparam int LN_DEB  = 2;
  localparam int LN_LVL  = 3;

  localparam logic [ADDR_W-1:0] OFF_DIR     = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_DIR_OUT = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_DIR_IN  = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_PIN     = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_OUT_SET = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_OUT_CLR = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_CTL_SET = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_CTL_CLR = 6'h1C;
  localparam logic [ADDR_W-1:0] OFF_ST_CLR  = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_ST      = 6'h24;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      dout   <= '0;
    end else begin
      meta_q <= din;
      dout   <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic q
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;

  // q follows din only after CYC consecutive samples that differ from q
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      q     <= 1'b0;
    end else if (din == q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      q     <= din;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NPIN    = 32,
  parameter int DEB_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic              irq
);
  localparam int L = LANE_W;

  logic [NPIN-1:0] ctl_q;
  logic [L-1:0]    st_q;
  logic [NPIN-1:0] pv;
  logic [L-1:0]    filt;
  logic [L-1:0]    prv_q;

  logic wr_en, rd_en;
  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  gpio_sync #(.W(NPIN)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pin_in),
    .dout (pv)
  );

  for (genvar g = 0; g < L; g++) begin : g_deb
    gpio_debounce #(.CYC(DEB_CYC)) u_deb (
      .clk (clk),
      .rst (rst),
      .din (pv[g]),
      .q   (filt[g])
    );
  end

  // lane decode
  logic [L-1:0] rise_en, fall_en, deb_en, lvl_en;
  assign rise_en = ctl_q[LN_RISE*L +: L];
  assign fall_en = ctl_q[LN_FALL*L +: L];
  assign deb_en  = ctl_q[LN_DEB*L  +: L];
  assign lvl_en  = ctl_q[LN_LVL*L  +: L];

  logic [L-1:0] det, ev_edge, ev_lvl, ev, clr, st_nxt;

  always_comb begin
    det     = (deb_en & filt) | (~deb_en & pv[L-1:0]);
    ev_edge = (rise_en & det & ~prv_q) | (fall_en & ~det & prv_q);
    ev_lvl  = (rise_en & det) | (fall_en & ~det);
    ev      = (lvl_en & ev_lvl) | (~lvl_en & ev_edge);
    clr     = (wr_en && bus_addr == OFF_ST_CLR) ? bus_wdata[L-1:0] : '0;
    st_nxt  = (st_q & ~clr) | ev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_oe    <= '0;
      pin_out   <= '0;
      ctl_q     <= '0;
      st_q      <= '0;
      prv_q     <= '0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      prv_q <= det;
      st_q  <= st_nxt;
      irq   <= |st_nxt;
      if (wr_en) begin
        case (bus_addr)
          OFF_DIR_OUT: pin_oe  <= pin_oe  | bus_wdata;
          OFF_DIR_IN:  pin_oe  <= pin_oe  & ~bus_wdata;
          OFF_OUT_SET: pin_out <= pin_out | bus_wdata;
          OFF_OUT_CLR: pin_out <= pin_out & ~bus_wdata;
          OFF_CTL_SET: ctl_q   <= ctl_q   | bus_wdata;
          OFF_CTL_CLR: ctl_q   <= ctl_q   & ~bus_wdata;
          default: ;
        endcase
      end
      if (rd_en) begin
        case (bus_addr)
          OFF_DIR:     bus_rdata <= pin_oe;
          OFF_PIN:     bus_rdata <= pv;
          OFF_OUT_SET: bus_rdata <= pin_out;
          OFF_CTL_SET: bus_rdata <= ctl_q;
          OFF_ST:      bus_rdata <= {{(NPIN-L){1'b0}}, st_q};
          default:     bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPIN-1:0]   bus_wdata,
  input logic [NPIN-1:0]   bus_rdata,
  input logic [NPIN-1:0]   pin_out,
  input logic [NPIN-1:0]   pin_oe,
  input logic              irq,
  input logic [LANE_W-1:0] st_q
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && pin_out == '0 && !irq)); // R1

  AST_DIR_SET: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_addr == OFF_DIR_OUT)
      |=> ((pin_oe & $past(bus_wdata)) == $past(bus_wdata))); // R2

  AST_OUT_CLR: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_addr == OFF_OUT_CLR)
      |=> ((pin_out & $past(bus_wdata)) == '0)); // R3

  AST_ST_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && bus_addr == OFF_ST)
      |=> (bus_rdata[NPIN-1:LANE_W] == '0)); // R10

  AST_IRQ_IS_OR: assert property (@(posedge clk) disable iff (rst)
    irq == (st_q != '0)); // R12

  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq && !(bus_sel && bus_wr && bus_addr == OFF_ST_CLR)) |=> irq); // R9
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPIN(NPIN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .st_q      (st_q)
);

// File: tb/sim_gpio_irq_bank.sv
module sim_gpio_irq_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] pin_in = '0;
  logic [31:0] bus_rdata, pin_out, pin_oe;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  gpio_irq_bank u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // tasks start and end just after a falling edge
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 pin_out", pin_out, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    rd(6'h18, d); chk("R1 ctl word", d, 0);
    rd(6'h24, d); chk("R1 status", d, 0);
  endtask

  task automatic t_dir();
    logic [31:0] d;
    wr(6'h04, 32'hA5A5_0F0F);
    rd(6'h00, d); chk("R2 dir set", d, 32'hA5A5_0F0F);
    wr(6'h08, 32'h0000_0F00);
    chk("R2 pin_oe after clear", pin_oe, 32'hA5A5_000F);
    wr(6'h04, 32'h0);
    rd(6'h00, d); chk("R2 zero write no effect", d, 32'hA5A5_000F);
  endtask

  task automatic t_out();
    logic [31:0] d;
    wr(6'h10, 32'hF000_0001);
    wr(6'h14, 32'h1000_0000);
    chk("R3 pin_out", pin_out, 32'hE000_0001);
    rd(6'h10, d); chk("R3 latch readback", d, 32'hE000_0001);
  endtask

  task automatic t_pinval();
    logic [31:0] d;
    pin_in = 32'h1234_5678;
    rd(6'h0C, d); chk("R4 sync edge1 old", d, 0);
    rd(6'h0C, d); chk("R4 sync edge2 old", d, 0);
    rd(6'h0C, d); chk("R4 sync edge3 new", d, 32'h1234_5678);
    pin_in = 0;
    ticks(4);
  endtask

  task automatic t_ctl();
    logic [31:0] d;
    wr(6'h18, 32'h8142_2418);
    wr(6'h1C, 32'h0040_0010);
    rd(6'h18, d); chk("R5 ctl set/clear", d, 32'h8102_2408);
    wr(6'h1C, 32'hFFFF_FFFF);
    rd(6'h18, d); chk("R5 ctl all clear", d, 0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    wr(6'h18, 32'h0000_0001);
    pin_in[0] = 1;
    ticks(2); chk("R6 not before edge3", {31'b0, irq}, 0);
    ticks(1); chk("R12 irq on edge3", {31'b0, irq}, 1);
    rd(6'h24, d); chk("R6 status rise", d, 32'h1);
    wr(6'h20, 32'h1);
    chk("R9 clear drops irq", {31'b0, irq}, 0);
    pin_in[0] = 0;
    ticks(4);
    rd(6'h24, d); chk("R6 fall ignored", d, 0);
    wr(6'h1C, 32'hFFFF_FFFF);
  endtask

  task automatic t_fall_both();
    logic [31:0] d;
    wr(6'h18, 32'h0000_0604); // fall pin1, both pin2
    pin_in[2:1] = 2'b11;
    ticks(4);
    rd(6'h24, d); chk("R7 rise: only both-pin", d, 32'h4);
    wr(6'h20, 32'h6);
    pin_in[2:1] = 2'b00;
    ticks(4);
    rd(6'h24, d); chk("R7 fall: fall and both", d, 32'h6);
    wr(6'h20, 32'h6);
    wr(6'h1C, 32'hFFFF_FFFF);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(6'h18, 32'h0800_0008); // level high pin3
    ticks(3);
    rd(6'h24, d); chk("R8 inactive low", d, 0);
    pin_in[3] = 1;
    ticks(4);
    wr(6'h20, 32'h8);
    rd(6'h24, d); chk("R8 level survives clear", d, 32'h8);
    pin_in[3] = 0;
    ticks(4);
    wr(6'h20, 32'h8);
    rd(6'h24, d); chk("R8 cleared after release", d, 0);
    wr(6'h1C, 32'hFFFF_FFFF);
    wr(6'h18, 32'h1000_1000); // level low pin4, pin4 is low
    ticks(1);
    rd(6'h24, d); chk("R8 active low", d, 32'h10);
    pin_in[4] = 1;
    ticks(4);
    wr(6'h20, 32'h10);
    rd(6'h24, d); chk("R8 low released", d, 0);
    wr(6'h1C, 32'hFFFF_FFFF);
  endtask

  task automatic t_race();
    logic [31:0] d;
    wr(6'h18, 32'h0000_0020); // rise pin5
    pin_in[5] = 1;
    ticks(4);
    pin_in[5] = 0;
    ticks(4);
    wr(6'h20, 32'h20);
    rd(6'h24, d); chk("R9 plain clear", d, 0);
    pin_in[5] = 1;
    ticks(2);
    wr(6'h20, 32'h20); // lands on the edge of the new event
    rd(6'h24, d); chk("R9 event beats clear", d, 32'h20);
    wr(6'h20, 32'h20);
    rd(6'h24, d); chk("R9 later clear", d, 0);
    wr(6'h1C, 32'hFFFF_FFFF);
  endtask

  task automatic t_high_pins();
    logic [31:0] d;
    wr(6'h18, 32'h0000_FFFF);
    pin_in[31:8] = 24'hFFFFFF;
    ticks(4);
    pin_in[31:8] = 24'h0;
    ticks(4);
    rd(6'h24, d); chk("R10 upper pins silent", d, 0);
    chk("R10 irq low", {31'b0, irq}, 0);
    wr(6'h1C, 32'hFFFF_FFFF);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(6'h18, 32'h0000_0040);
    wr(6'h1C, 32'h0000_4040);
    pin_in[6] = 1;
    ticks(4);
    rd(6'h24, d); chk("R13 masked pin", d, 0);
  endtask

  task automatic t_debounce();
    logic [31:0] d;
    wr(6'h18, 32'h0080_0080); // rise + debounce pin7
    ticks(2);
    pin_in[7] = 1;
    ticks(10);
    pin_in[7] = 0;
    ticks(30);
    chk("R11 short pulse dropped", {31'b0, irq}, 0);
    pin_in[7] = 1;
    ticks(18); chk("R11 not at edge18", {31'b0, irq}, 0);
    ticks(1);  chk("R11 at edge19", {31'b0, irq}, 1);
    wr(6'h20, 32'h80);
    rd(6'h24, d); chk("R11 cleared", d, 0);
    wr(6'h1C, 32'hFFFF_FFFF);
  endtask

  initial begin
    ticks(3);
    rst = 0;
    ticks(1);
    t_reset();
    t_dir();
    t_out();
    t_pinval();
    t_ctl();
    t_rise();
    t_fall_both();
    t_level();
    t_race();
    t_high_pins();
    t_mask();
    t_debounce();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule